// File: doc/BRIEF.md
# Packed Ternary Matrix-Vector Engine

This block forms one output vector y = W·x, where every weight is −1, 0 or +1 and every activation is a signed 8-bit integer. No hardware multiplier is used anywhere. Each weight times activation product comes from a three-way choice: pass the activation, zero it, or negate it. Weights arrive as packed bytes on a valid/ready stream. Each byte carries five base-3 digits, which a combinational decoder turns into five 2-bit weight codes as the bytes come in.

A tile is K = 5·NB weights, one stream beat of NB bytes. The tile's lane products are reduced by an adder tree and summed over the NT tiles of a row into a 32-bit accumulator. The activation vector is loaded beforehand, one tile of K values per write, into a block-style buffer with a single clock-only process. During a run that buffer is read one tile per beat, in order. The datapath has three pipeline stages (decode and select, reduce, accumulate), so it takes one tile per clock cycle. A one-cycle result pulse marks each finished row.

A host loads the activations, starts a run with a row count M and a tile count NT, and then streams M·NT weight beats, row by row and tile by tile within a row.

Top module: `tgemv_engine`

## Requirements
- R1: During and right after reset, `busy`, `w_ready` and `y_valid` are all 0.
- R2: Byte value v equals d0 + 3·d1 + 9·d2 + 27·d3 + 81·d4, with trit d0 the least significant. Digit dj of byte b of a beat is the weight of lane 5b+j. Digit 0 means weight 0, digit 1 means +1, and digit 2 means −1. The weight code is 00 for 0, 01 for +1 and 10 for −1.
- R3: A weight byte whose value is 243 to 255 acts as five zero weights.
- R4: Each lane adds +a, 0 or −a for its int8 activation a, and the result is exact for a = −128 (negating it gives +128).
- R5: The result of row r equals the sum, over tiles t and lanes l, of w(r,t,l)·x(t,l). Activation x(t,l) is bits [8l+7:8l] of the word written to activation address t.
- R6: A `start` is accepted only while idle and only with `cfg_rows` ≥ 1 and `cfg_tiles` ≥ 1. A `start` while busy, or with either count 0, is ignored.
- R7: `w_ready` is high exactly while weight beats of the current run are still owed. A beat is taken on every clock edge where `w_valid` and `w_ready` are both high, and cycles with `w_valid` low do not disturb the result.
- R8: Each row produces exactly one single-cycle `y_valid` pulse, with its value on `y_data`, and the rows come out in order.
- R9: A row's `y_valid` pulse begins on the third rising clock edge after the edge that accepts the row's last beat.
- R10: After the last result, `busy` and `w_ready` return to 0 and a new run may be started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run with the counts below |
| cfg_rows | input | ROW_W | Number of output rows M |
| cfg_tiles | input | TILE_W | Tiles per row NT (1 to ACT_TILES) |
| busy | output | 1 | A run is in progress or draining |
| act_we | input | 1 | Activation tile write strobe |
| act_waddr | input | AW | Activation tile address |
| act_wdata | input | 8·K | K int8 activations, lane l in bits [8l+7:8l] |
| w_valid | input | 1 | Weight beat valid |
| w_ready | output | 1 | Engine accepts a weight beat |
| w_data | input | 8·NB | NB packed weight bytes, byte b feeds lanes 5b..5b+4 |
| y_valid | output | 1 | One-cycle pulse with a finished row |
| y_data | output | 32 | Signed row result |

## Verification
The assertions assume that `cfg_tiles` never exceeds the activation buffer depth. They also assume that activation tiles are written before a run starts and are left alone while it runs, because the pipeline reads the buffer during the run. The bench keeps to this: it loads every activation tile while the engine is idle, it uses at most 16 tiles per row, and it changes `start` during a run only to show that the pulse is ignored. The weight stream itself is unconstrained, so the bench drives illegal byte values and random gaps in `w_valid` freely.

// File: rtl/tgemv_pkg.sv
// Shared constants and types for the packed ternary matrix-vector engine.
// Assumes int8 activations, 9-bit lane products and a 32-bit accumulator.
package tgemv_pkg;
    localparam int TRITS      = 5;    // base-3 digits per packed byte
    localparam int BYTE_LIMIT = 242;  // largest legal packed byte value
    localparam int ACT_W      = 8;    // activation width
    localparam int PROD_W     = 9;    // lane product width (holds +128)
    localparam int ACC_W      = 32;   // row accumulator width

    // Weight codes: 00 zero, 01 plus one, 10 minus one, 11 spare (treated as zero)
    localparam logic [1:0] WC_ZERO = 2'b00;
    localparam logic [1:0] WC_POS  = 2'b01;
    localparam logic [1:0] WC_NEG  = 2'b10;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} eng_state_t;
endpackage

// File: rtl/tgemv_unpack.sv
// Combinational decoder: one packed byte to five 2-bit weight codes.
// Digit 0 is the least significant base-3 digit. Bytes above the legal
// range decode to all-zero weights.
module tgemv_unpack
    import tgemv_pkg::*;
(
    input  logic [7:0]             packed_byte,
    output logic [TRITS-1:0][1:0]  codes
);
    logic [7:0] rest;
    logic [7:0] digit;

    // Peel off base-3 digits one at a time and map each one to a weight code
    always_comb begin
        rest = packed_byte;
        for (int j = 0; j < TRITS; j++) begin
            digit = rest % 8'd3;
            rest  = rest / 8'd3;
            if (packed_byte > 8'(BYTE_LIMIT))
                codes[j] = WC_ZERO;
            else if (digit == 8'd1)
                codes[j] = WC_POS;
            else if (digit == 8'd2)
                codes[j] = WC_NEG;
            else
                codes[j] = WC_ZERO;
        end
    end
endmodule

// File: rtl/tgemv_lanes.sv
// Sign/zero select lanes: each lane passes, zeroes or negates its int8
// activation according to its weight code. No multiplier is used.
// Assumes the activation is signed two's complement.
module tgemv_lanes
    import tgemv_pkg::*;
#(
    parameter int LANES = 10
)(
    input  logic [LANES-1:0][1:0]        codes,
    input  logic [LANES-1:0][ACT_W-1:0]  acts,
    output logic [LANES-1:0][PROD_W-1:0] prods
);
    logic [PROD_W-1:0] ext;

    // Sign-extend each activation, then pick +a, -a or zero
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            ext = {acts[l][ACT_W-1], acts[l]};
            case (codes[l])
                WC_POS:  prods[l] = ext;
                WC_NEG:  prods[l] = -ext;
                default: prods[l] = '0;
            endcase
        end
    end
endmodule

// File: rtl/tgemv_actbuf.sv
// Activation buffer: one word of a whole tile per address. Write and
// registered read sit in one clock-only process so that it maps to
// block memory. The contents are not reset.
module tgemv_actbuf #(
    parameter int WIDTH = 80,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    // Store on a write, fetch a tile word on a read
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/tgemv_engine.sv
// Packed ternary matrix-vector engine top.
// Takes one tile of K = 5*NB weights per beat. Stage 1 holds the weight
// bytes and the activation word. Stage 2 holds the selected lane products.
// Stage 3 holds the reduced tile sum. The accumulator then closes each row.
// Assumes cfg_tiles <= ACT_TILES and no activation writes during a run.
module tgemv_engine
    import tgemv_pkg::*;
#(
    parameter int NB        = 2,
    parameter int ACT_TILES = 16,
    parameter int ROW_W     = 8,
    localparam int K        = NB * TRITS,
    localparam int AW       = $clog2(ACT_TILES),
    localparam int TILE_W   = $clog2(ACT_TILES + 1)
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ROW_W-1:0]    cfg_rows,
    input  logic [TILE_W-1:0]   cfg_tiles,
    output logic                busy,
    input  logic                act_we,
    input  logic [AW-1:0]       act_waddr,
    input  logic [K*ACT_W-1:0]  act_wdata,
    input  logic                w_valid,
    output logic                w_ready,
    input  logic [NB*8-1:0]     w_data,
    output logic                y_valid,
    output logic [ACC_W-1:0]    y_data
);
    localparam int SUM_W = PROD_W + $clog2(K);

    eng_state_t               state;
    logic [ROW_W-1:0]         rows_q, row_idx;
    logic [TILE_W-1:0]        tiles_q, tile_idx;
    logic                     accept, launch, first_tile, last_tile, last_row;

    logic                     st1_v, st1_first, st1_last;
    logic [NB*8-1:0]          st1_bytes;
    logic [K*ACT_W-1:0]       act_rd;
    logic [K-1:0][1:0]        lane_codes;
    logic [K-1:0][PROD_W-1:0] lane_prod;

    logic                     st2_v, st2_first, st2_last;
    logic [K-1:0][PROD_W-1:0] st2_prod;
    logic [SUM_W-1:0]         tile_sum;

    logic                     st3_v, st3_first, st3_last;
    logic [SUM_W-1:0]         st3_sum;
    logic [ACC_W-1:0]         acc, acc_next;

    assign busy       = (state != ST_IDLE);
    assign w_ready    = (state == ST_RUN);
    assign accept     = w_valid && w_ready;
    assign launch     = (state == ST_IDLE) && start && (cfg_rows != '0) && (cfg_tiles != '0);
    assign first_tile = (tile_idx == '0);
    assign last_tile  = (tile_idx == tiles_q - TILE_W'(1));
    assign last_row   = (row_idx == rows_q - ROW_W'(1));

    // Run control: latch the counts, walk the tiles and rows, drain the pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            rows_q   <= '0;
            tiles_q  <= '0;
            row_idx  <= '0;
            tile_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: if (launch) begin
                    rows_q   <= cfg_rows;
                    tiles_q  <= cfg_tiles;
                    row_idx  <= '0;
                    tile_idx <= '0;
                    state    <= ST_RUN;
                end
                ST_RUN: if (accept) begin
                    if (last_tile) begin
                        tile_idx <= '0;
                        row_idx  <= row_idx + ROW_W'(1);
                        if (last_row) state <= ST_DRAIN;
                    end else begin
                        tile_idx <= tile_idx + TILE_W'(1);
                    end
                end
                ST_DRAIN: if (!st1_v && !st2_v && !st3_v) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    tgemv_actbuf #(.WIDTH(K*ACT_W), .DEPTH(ACT_TILES)) u_actbuf (
        .clk   (clk),
        .we    (act_we),
        .waddr (act_waddr),
        .wdata (act_wdata),
        .re    (accept),
        .raddr (AW'(tile_idx)),
        .rdata (act_rd)
    );

    // Stage 1: hold the accepted weight bytes and the row-position flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_v     <= 1'b0;
            st1_first <= 1'b0;
            st1_last  <= 1'b0;
            st1_bytes <= '0;
        end else begin
            st1_v <= accept;
            if (accept) begin
                st1_bytes <= w_data;
                st1_first <= first_tile;
                st1_last  <= last_tile;
            end
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_unpack
        tgemv_unpack u_unpack (
            .packed_byte (st1_bytes[8*b +: 8]),
            .codes       (lane_codes[TRITS*b +: TRITS])
        );
    end

    tgemv_lanes #(.LANES(K)) u_lanes (
        .codes (lane_codes),
        .acts  (act_rd),
        .prods (lane_prod)
    );

    // Stage 2: register the selected lane products
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st2_v     <= 1'b0;
            st2_first <= 1'b0;
            st2_last  <= 1'b0;
            st2_prod  <= '0;
        end else begin
            st2_v     <= st1_v;
            st2_first <= st1_first;
            st2_last  <= st1_last;
            st2_prod  <= lane_prod;
        end
    end

    // Adder tree: reduce the sign-extended lane products of one tile
    always_comb begin
        tile_sum = '0;
        for (int l = 0; l < K; l++)
            tile_sum = tile_sum + {{(SUM_W-PROD_W){st2_prod[l][PROD_W-1]}}, st2_prod[l]};
    end

    // Stage 3: register the tile sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st3_v     <= 1'b0;
            st3_first <= 1'b0;
            st3_last  <= 1'b0;
            st3_sum   <= '0;
        end else begin
            st3_v     <= st2_v;
            st3_first <= st2_first;
            st3_last  <= st2_last;
            st3_sum   <= tile_sum;
        end
    end

    // Next accumulator value: restart on a row's first tile
    always_comb begin
        acc_next = (st3_first ? '0 : acc) + {{(ACC_W-SUM_W){st3_sum[SUM_W-1]}}, st3_sum};
    end

    // Accumulate tiles and present each row's final value with a pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            y_valid <= 1'b0;
            y_data  <= '0;
        end else begin
            y_valid <= st3_v && st3_last;
            if (st3_v) acc <= acc_next;
            if (st3_v && st3_last) y_data <= acc_next;
        end
    end

    // R6: the latched counts stay fixed for the whole run
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(rows_q) && $stable(tiles_q)));

    // R8: result pulses occur only inside a run
    p_pulse_in_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        y_valid |-> busy);

    for (genvar l = 0; l < K; l++) begin : g_lane_chk
        // R4: each registered product is +a, 0 or -a of the fetched activation
        p_lane_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
            st2_v |-> (st2_prod[l] == '0
                    || st2_prod[l] == $past({act_rd[ACT_W*l+ACT_W-1], act_rd[ACT_W*l +: ACT_W]})
                    || st2_prod[l] == -$past({act_rd[ACT_W*l+ACT_W-1], act_rd[ACT_W*l +: ACT_W]})));
    end

    for (genvar b = 0; b < NB; b++) begin : g_byte_chk
        // R3: an out-of-range byte yields zero products on all its lanes
        p_bad_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (st1_v && st1_bytes[8*b +: 8] > 8'(BYTE_LIMIT)) |=> (st2_prod[TRITS*b +: TRITS] == '0));
    end
endmodule

// File: tb/tgemv_engine_test.sv
// Self-checking bench: a table of run vectors walked by one loop, then
// directed checks for reset, ignored starts and the idle stream.
module tgemv_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB         = 2;
    localparam int TR         = 5;
    localparam int K          = NB * TR;
    localparam int ACT_TILES  = 16;
    localparam int ROW_W      = 8;
    localparam int AW         = 4;
    localparam int TILE_W     = 5;
    localparam int MAXR       = 8;
    localparam int RND        = 999;  // activation field value meaning random
    localparam int NVEC       = 8;

    // rows, tiles, const-weight flag, weight byte, activation, stall, late start
    localparam int VEC [NVEC][7] = '{
        '{1, 1,  0, 0,   RND,  0, 0},
        '{4, 3,  0, 0,   RND,  1, 0},
        '{2, 16, 1, 242, -128, 0, 0},
        '{3, 2,  1, 250, RND,  0, 0},
        '{8, 1,  0, 0,   RND,  1, 0},
        '{1, 4,  1, 1,   RND,  0, 0},
        '{2, 3,  1, 3,   RND,  0, 1},
        '{2, 2,  1, 121, 127,  0, 0}
    };
    localparam string TAG [NVEC] = '{"R5", "R7", "R4", "R3", "R8", "R2", "R6", "R5"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ROW_W-1:0] cfg_rows = '0;
    logic [TILE_W-1:0] cfg_tiles = '0;
    logic busy;
    logic act_we = 1'b0;
    logic [AW-1:0] act_waddr = '0;
    logic [K*8-1:0] act_wdata = '0;
    logic w_valid = 1'b0;
    logic w_ready;
    logic [NB*8-1:0] w_data = '0;
    logic y_valid;
    logic [31:0] y_data;

    int nchk = 0, nfail = 0, cyc = 0, cap_n = 0, last_acc = 0;
    int cap [64];
    int cap_cyc [64];
    int act [ACT_TILES][K];
    int wb [MAXR*ACT_TILES*NB];
    int expv [MAXR];
    int unsigned rs = 32'h1234_5678;
    bit finished = 1'b0;

    tgemv_engine #(.NB(NB), .ACT_TILES(ACT_TILES), .ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_rows(cfg_rows),
        .cfg_tiles(cfg_tiles), .busy(busy), .act_we(act_we),
        .act_waddr(act_waddr), .act_wdata(act_wdata), .w_valid(w_valid),
        .w_ready(w_ready), .w_data(w_data), .y_valid(y_valid), .y_data(y_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Capture result pulses half a cycle after the edge
    always @(negedge clk) begin
        if (rst_n && y_valid && cap_n < 64) begin
            cap[cap_n]     = int'($signed(y_data));
            cap_cyc[cap_n] = cyc;
            cap_n          = cap_n + 1;
        end
    end

    function automatic int unsigned rnd();
        rs = rs * 32'd1103515245 + 32'd12345;
        return rs >> 16;
    endfunction

    // Weight of digit j of byte v per R2/R3
    function automatic int tw(int v, int j);
        int d = v;
        if (v > 242) return 0;
        for (int i = 0; i < j; i++) d = d / 3;
        d = d % 3;
        return (d == 0) ? 0 : ((d == 1) ? 1 : -1);
    endfunction

    task automatic check(bit ok, string req, int got, int expd);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, got, expd);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic run_vec(int rows, int tiles, int wconst_on, int wconst,
                           int aval, int stall, int poke, string tag);
        logic [7:0] tmp8;
        int s, beat, guard;
        for (int t = 0; t < tiles; t++)
            for (int l = 0; l < K; l++) begin
                tmp8 = 8'(rnd());
                act[t][l] = (aval == RND) ? int'($signed(tmp8)) : aval;
            end
        for (int t = 0; t < tiles; t++) begin
            @(negedge clk);
            act_we = 1'b1;
            act_waddr = AW'(t);
            for (int l = 0; l < K; l++) act_wdata[8*l +: 8] = 8'(act[t][l]);
        end
        @(negedge clk);
        act_we = 1'b0;
        for (int i = 0; i < rows*tiles*NB; i++) wb[i] = wconst_on ? wconst : int'(rnd() % 256);
        for (int r = 0; r < rows; r++) begin
            s = 0;
            for (int t = 0; t < tiles; t++)
                for (int b = 0; b < NB; b++)
                    for (int j = 0; j < TR; j++)
                        s += tw(wb[(r*tiles+t)*NB+b], j) * act[t][b*TR+j];
            expv[r] = s;
        end
        cap_n = 0;
        start = 1'b1;
        cfg_rows = ROW_W'(rows);
        cfg_tiles = TILE_W'(tiles);
        @(negedge clk);
        start = 1'b0;
        beat = 0;
        guard = 0;
        while (beat < rows*tiles && guard < 5000) begin
            guard++;
            if (stall != 0 && rnd() % 3 == 0) w_valid = 1'b0;
            else w_valid = 1'b1;
            for (int b = 0; b < NB; b++) w_data[8*b +: 8] = 8'(wb[beat*NB+b]);
            if (poke != 0 && beat == 1) begin
                start = 1'b1;
                cfg_rows = 8'd5;
                cfg_tiles = 5'd1;
            end else begin
                start = 1'b0;
            end
            #1;
            if (w_valid && w_ready) begin
                last_acc = cyc + 1;
                beat++;
            end
            @(negedge clk);
        end
        w_valid = 1'b0;
        start = 1'b0;
        guard = 0;
        while (busy && guard < 100) begin
            guard++;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        check(cap_n == rows, "R8 pulse count", cap_n, rows);
        for (int r = 0; r < rows && r < cap_n; r++)
            check(cap[r] == expv[r], tag, cap[r], expv[r]);
        if (cap_n == rows)
            check(cap_cyc[rows-1] - last_acc == 3, "R9 latency", cap_cyc[rows-1] - last_acc, 3);
        check(!busy && !w_ready, "R10 idle after run", int'(busy) + int'(w_ready), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !w_ready && !y_valid, "R1 in reset",
              int'(busy) + int'(w_ready) + int'(y_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !w_ready && !y_valid, "R1 after reset",
              int'(busy) + int'(w_ready) + int'(y_valid), 0);

        // R6: zero counts are ignored; R7: no ready while idle
        start = 1'b1; cfg_rows = 8'd0; cfg_tiles = 5'd3; w_valid = 1'b1;
        @(negedge clk);
        check(!busy, "R6 zero rows", int'(busy), 0);
        check(!w_ready, "R7 idle ready", int'(w_ready), 0);
        cfg_rows = 8'd2; cfg_tiles = 5'd0;
        @(negedge clk);
        check(!busy, "R6 zero tiles", int'(busy), 0);
        start = 1'b0; w_valid = 1'b0;
        @(negedge clk);
        check(!y_valid, "R8 no pulse when idle", int'(y_valid), 0);

        // Table of run vectors
        for (int v = 0; v < NVEC; v++)
            run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3],
                    VEC[v][4], VEC[v][5], VEC[v][6], TAG[v]);

        summary();
    end
endmodule